// File: doc/BRIEF.md
# Receive Packet Priority Classifier

This block gives every received packet a 2-bit receive queue priority. A header parser in front of it supplies, once per packet, the differentiated-services codepoint with a valid flag, the 3-bit VLAN priority tag with a valid flag, and two flags that mark a packet as a multicast group management message or as a spanning-tree bridge frame. Static configuration inputs hold the codepoint table, the VLAN tag table, a default priority and the controls that choose which source is used.

Both tables store each 2-bit priority in two separate bit planes. One plane holds the least significant bit of every entry and the other holds the most significant bit. The codepoint planes are each split into a half for codepoints 0 to 31 and a half for codepoints 32 to 63. The sources are ranked. A forced default wins first. A trapped management or bridge frame comes next. Then comes the codepoint lookup, if it is enabled and its field is valid, then the VLAN lookup, if the tag is valid. The default priority is used last.

The result is registered. One classification is taken every clock, and each one appears on the output one cycle after its input.

Top module: `rxprio_classifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_prio` is 0.
- R2: `out_valid` in cycle n+1 equals `in_valid` in cycle n. A packet is accepted in every cycle with no gap.
- R3: When `cfg_force_dflt` is 1, the output priority equals `cfg_dflt_prio`, whatever the other inputs are.
- R4: When `cfg_force_dflt` is 0, `cfg_trap_igmp` is 1 and `is_igmp` is 1, the output priority is 3 (binary 11, the highest).
- R5: When `cfg_force_dflt` is 0, `cfg_trap_bpdu` is 1 and `is_bpdu` is 1, the output priority is 3.
- R6: A flagged packet whose trap enable is 0 is classified exactly as if its flag were 0.
- R7: The codepoint lookup for codepoint c returns {H,L}. L is `cfg_dscp_lo_a[c]` for c below 32 and `cfg_dscp_lo_b[c-32]` otherwise. H comes from `cfg_dscp_hi_a` and `cfg_dscp_hi_b` in the same way.
- R8: The codepoint lookup is used only when `cfg_dscp_en` is 1 and `dscp_ok` is 1. Otherwise the lower-ranked sources decide.
- R9: When no higher source applies and `vtag_ok` is 1, the priority for tag t is {`cfg_vlan_map[8+t]`, `cfg_vlan_map[t]`}.
- R10: When no override, trap, codepoint or tag applies, the priority is `cfg_dflt_prio`.
- R11: After a cycle with `in_valid` at 0, `out_valid` is 0 and `out_prio` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet's header fields are present this cycle |
| dscp | input | 6 | Differentiated-services codepoint |
| dscp_ok | input | 1 | Codepoint field is present |
| vtag | input | 3 | VLAN priority tag |
| vtag_ok | input | 1 | VLAN tag is present |
| is_igmp | input | 1 | Packet is a group management message |
| is_bpdu | input | 1 | Packet is a spanning-tree bridge frame |
| cfg_dscp_lo_a | input | 32 | Low priority bit, codepoints 0 to 31 |
| cfg_dscp_lo_b | input | 32 | Low priority bit, codepoints 32 to 63 |
| cfg_dscp_hi_a | input | 32 | High priority bit, codepoints 0 to 31 |
| cfg_dscp_hi_b | input | 32 | High priority bit, codepoints 32 to 63 |
| cfg_vlan_map | input | 16 | Low bits in [7:0], high bits in [15:8], indexed by tag |
| cfg_dflt_prio | input | 2 | Default priority (0 lowest, 3 highest) |
| cfg_force_dflt | input | 1 | Give every packet the default priority |
| cfg_dscp_en | input | 1 | Enable the codepoint lookup |
| cfg_trap_igmp | input | 1 | Send group management packets to priority 3 |
| cfg_trap_bpdu | input | 1 | Send bridge frames to priority 3 |
| out_valid | output | 1 | Classification result is present |
| out_prio | output | 2 | Assigned priority |

## Verification
A single packet can qualify for several sources at once. It may be trapped while also carrying a valid codepoint and tag, and the forced default may be set on top of all of them. The ranking is the function under test in those cycles. Random stimulus sets every flag and enable independently, so these overlaps occur often. Directed packets also raise all flags together with the override set and then cleared. Each result is compared against a bench model that applies the ranking from the requirements.

// File: rtl/rxprio_pkg.sv
`timescale 1ns/1ps
package rxprio_pkg;
    localparam int PRIO_W = 2;
    localparam logic [PRIO_W-1:0] PRIO_TOP = '1;

    typedef enum logic [2:0] {
        SRC_FORCE = 3'd0,
        SRC_TRAP  = 3'd1,
        SRC_CODE  = 3'd2,
        SRC_TAG   = 3'd3,
        SRC_DFLT  = 3'd4
    } prio_src_e;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
    } cls_state_t;
endpackage

// File: rtl/rxprio_plane_pick.sv
`timescale 1ns/1ps
// Selects one bit of a bit plane by index.
module rxprio_plane_pick #(
    parameter int IDX_W = 6,
    localparam int N = 1 << IDX_W
) (
    input  logic [N-1:0]     plane,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    always_comb begin
        bit_o = plane[idx];
    end
endmodule

// File: rtl/rxprio_table.sv
`timescale 1ns/1ps
// Two-plane priority table: one plane per priority bit.
module rxprio_table #(
    parameter int IDX_W = 6,
    localparam int N = 1 << IDX_W
) (
    input  logic [N-1:0]                   plane_lo,
    input  logic [N-1:0]                   plane_hi,
    input  logic [IDX_W-1:0]               idx,
    output logic [rxprio_pkg::PRIO_W-1:0]  prio
);
    logic [rxprio_pkg::PRIO_W-1:0][N-1:0] planes;
    assign planes[0] = plane_lo;
    assign planes[1] = plane_hi;

    for (genvar p = 0; p < rxprio_pkg::PRIO_W; p++) begin : g_plane
        rxprio_plane_pick #(.IDX_W(IDX_W)) u_pick (
            .plane (planes[p]),
            .idx   (idx),
            .bit_o (prio[p])
        );
    end
endmodule

// File: rtl/rxprio_rank.sv
`timescale 1ns/1ps
// Ranked selection among the priority sources.
module rxprio_rank
    import rxprio_pkg::*;
(
    input  logic              force_dflt,
    input  logic              trap_hit,
    input  logic              code_use,
    input  logic              tag_use,
    input  logic [PRIO_W-1:0] code_prio,
    input  logic [PRIO_W-1:0] tag_prio,
    input  logic [PRIO_W-1:0] dflt_prio,
    output logic [PRIO_W-1:0] prio
);
    prio_src_e src;

    always_comb begin
        if (force_dflt)    src = SRC_FORCE;
        else if (trap_hit) src = SRC_TRAP;
        else if (code_use) src = SRC_CODE;
        else if (tag_use)  src = SRC_TAG;
        else               src = SRC_DFLT;
    end

    always_comb begin
        unique case (src)
            SRC_TRAP: prio = PRIO_TOP;
            SRC_CODE: prio = code_prio;
            SRC_TAG:  prio = tag_prio;
            default:  prio = dflt_prio;
        endcase
    end
endmodule

// File: rtl/rxprio_classifier.sv
`timescale 1ns/1ps
module rxprio_classifier
    import rxprio_pkg::*;
#(
    parameter int DSCP_W = 6,
    parameter int TAG_W = 3,
    localparam int DSCP_N = 1 << DSCP_W,
    localparam int HALF_N = DSCP_N / 2,
    localparam int TAG_N = 1 << TAG_W,
    localparam int MAP_W = TAG_N * PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DSCP_W-1:0] dscp,
    input  logic              dscp_ok,
    input  logic [TAG_W-1:0]  vtag,
    input  logic              vtag_ok,
    input  logic              is_igmp,
    input  logic              is_bpdu,
    input  logic [HALF_N-1:0] cfg_dscp_lo_a,
    input  logic [HALF_N-1:0] cfg_dscp_lo_b,
    input  logic [HALF_N-1:0] cfg_dscp_hi_a,
    input  logic [HALF_N-1:0] cfg_dscp_hi_b,
    input  logic [MAP_W-1:0]  cfg_vlan_map,
    input  logic [PRIO_W-1:0] cfg_dflt_prio,
    input  logic              cfg_force_dflt,
    input  logic              cfg_dscp_en,
    input  logic              cfg_trap_igmp,
    input  logic              cfg_trap_bpdu,
    output logic              out_valid,
    output logic [PRIO_W-1:0] out_prio
);
    logic [PRIO_W-1:0] code_prio, tag_prio, sel_prio;
    logic              trap_hit, code_use;
    cls_state_t        st_d, st_q;

    rxprio_table #(.IDX_W(DSCP_W)) u_code_tbl (
        .plane_lo ({cfg_dscp_lo_b, cfg_dscp_lo_a}),
        .plane_hi ({cfg_dscp_hi_b, cfg_dscp_hi_a}),
        .idx      (dscp),
        .prio     (code_prio)
    );

    rxprio_table #(.IDX_W(TAG_W)) u_tag_tbl (
        .plane_lo (cfg_vlan_map[TAG_N-1:0]),
        .plane_hi (cfg_vlan_map[MAP_W-1:TAG_N]),
        .idx      (vtag),
        .prio     (tag_prio)
    );

    assign trap_hit = (cfg_trap_igmp & is_igmp) | (cfg_trap_bpdu & is_bpdu);
    assign code_use = cfg_dscp_en & dscp_ok;

    rxprio_rank u_rank (
        .force_dflt (cfg_force_dflt),
        .trap_hit   (trap_hit),
        .code_use   (code_use),
        .tag_use    (vtag_ok),
        .code_prio  (code_prio),
        .tag_prio   (tag_prio),
        .dflt_prio  (cfg_dflt_prio),
        .prio       (sel_prio)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.prio = sel_prio;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_prio  = st_q.prio;

    a_r2_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    a_r3_forced_default: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_force_dflt) |=> (out_prio == $past(cfg_dflt_prio)));

    a_r4_igmp_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_force_dflt && cfg_trap_igmp && is_igmp) |=> (out_prio == PRIO_TOP));

    a_r5_bpdu_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_force_dflt && cfg_trap_bpdu && is_bpdu) |=> (out_prio == PRIO_TOP));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_prio)));
endmodule

// File: tb/sim_rxprio_classifier.sv
`timescale 1ns/1ps
module sim_rxprio_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  dscp = '0;
    logic        dscp_ok = 1'b0;
    logic [2:0]  vtag = '0;
    logic        vtag_ok = 1'b0;
    logic        is_igmp = 1'b0;
    logic        is_bpdu = 1'b0;
    logic [31:0] lo_a = '0, lo_b = '0, hi_a = '0, hi_b = '0;
    logic [15:0] vmap = '0;
    logic [1:0]  dflt = '0;
    logic        force_d = 1'b0, code_en = 1'b0, trap_i = 1'b0, trap_b = 1'b0;
    logic        out_valid;
    logic [1:0]  out_prio;

    int checks = 0;
    int errors = 0;
    logic [1:0] last_prio = '0;

    always #5 clk = ~clk;

    rxprio_classifier u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dscp(dscp), .dscp_ok(dscp_ok),
        .vtag(vtag), .vtag_ok(vtag_ok), .is_igmp(is_igmp), .is_bpdu(is_bpdu),
        .cfg_dscp_lo_a(lo_a), .cfg_dscp_lo_b(lo_b), .cfg_dscp_hi_a(hi_a), .cfg_dscp_hi_b(hi_b),
        .cfg_vlan_map(vmap), .cfg_dflt_prio(dflt), .cfg_force_dflt(force_d),
        .cfg_dscp_en(code_en), .cfg_trap_igmp(trap_i), .cfg_trap_bpdu(trap_b),
        .out_valid(out_valid), .out_prio(out_prio)
    );

    function automatic logic [1:0] model();
        logic [63:0] pl, ph;
        pl = {lo_b, lo_a};
        ph = {hi_b, hi_a};
        if (force_d) return dflt;
        if ((trap_i && is_igmp) || (trap_b && is_bpdu)) return 2'b11;
        if (code_en && dscp_ok) return {ph[dscp], pl[dscp]};
        if (vtag_ok) return {vmap[8 + int'(vtag)], vmap[vtag]};
        return dflt;
    endfunction

    function automatic string tag_of();
        if (force_d) return "R3";
        if (trap_i && is_igmp) return "R4";
        if (trap_b && is_bpdu) return "R5";
        if (code_en && dscp_ok) return "R7";
        if (vtag_ok) return "R9";
        return "R10";
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of input; sample one time step after the capturing edge.
    task automatic step(string req);
        logic [1:0] exp_p;
        string t;
        @(negedge clk);
        exp_p = in_valid ? model() : last_prio;
        t = (req == "") ? tag_of() : req;
        @(posedge clk);
        #1;
        check("R2", {1'b0, out_valid}, {1'b0, in_valid});
        check(in_valid ? t : "R11", out_prio, exp_p);
        last_prio = exp_p;
    endtask

    task automatic pkt(logic [5:0] d, logic dok, logic [2:0] t, logic tok, logic ig, logic bp);
        @(negedge clk);
        in_valid = 1'b1; dscp = d; dscp_ok = dok; vtag = t; vtag_ok = tok;
        is_igmp = ig; is_bpdu = bp;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        #1;
        check("R1", {out_valid, out_prio}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", {out_valid, out_prio}, 3'b000);

        lo_a = 32'h0000_0001; hi_a = 32'h8000_0000;
        lo_b = 32'h8000_0000; hi_b = 32'h0000_0001;
        vmap = 16'h80_01; dflt = 2'd1; code_en = 1'b1;

        // R3: override beats everything, including traps
        force_d = 1'b1; trap_i = 1'b1; trap_b = 1'b1;
        pkt(6'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1); step("R3");
        force_d = 1'b0;
        // R4 / R5: traps beat codepoint and tag
        pkt(6'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0); step("R4");
        pkt(6'd0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1); step("R5");
        // R6: flags with traps disabled fall through to the codepoint
        trap_i = 1'b0; trap_b = 1'b0;
        pkt(6'd0, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1); step("R6");
        // R7: codepoint plane boundaries 0, 31, 32, 63 -> 1, 2, 2, 1
        pkt(6'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0); step("R7");
        pkt(6'd31, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0); step("R7");
        pkt(6'd32, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0); step("R7");
        pkt(6'd63, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0); step("R7");
        // R8: codepoint disabled -> tag 7 gives 2
        code_en = 1'b0;
        pkt(6'd0, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0); step("R8");
        code_en = 1'b1;
        pkt(6'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0); step("R8");
        // R9: tag 0 gives 1, tag 7 gives 2
        pkt(6'd0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0); step("R9");
        // R10: nothing valid -> default
        dflt = 2'd3;
        pkt(6'd5, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0); step("R10");
        // R11: idle cycles keep the last priority
        @(negedge clk); in_valid = 1'b0; dflt = 2'd0; force_d = 1'b1;
        step("R11");
        step("R11");
        force_d = 1'b0;

        // Random traffic, back to back, with random configuration changes
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 40 == 0) begin
                lo_a = $urandom; lo_b = $urandom; hi_a = $urandom; hi_b = $urandom;
                vmap = 16'($urandom); dflt = 2'($urandom);
            end
            force_d = ($urandom % 8) == 0;
            code_en = 1'($urandom); trap_i = 1'($urandom); trap_b = 1'($urandom);
            in_valid = ($urandom % 6) != 0;
            dscp = 6'($urandom); dscp_ok = 1'($urandom);
            vtag = 3'($urandom); vtag_ok = 1'($urandom);
            is_igmp = ($urandom % 4) == 0; is_bpdu = ($urandom % 4) == 0;
            step("");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule